// File: doc/BRIEF.md
# Dual absolute encoder synchronous serial reader

This block reads two absolute rotary encoders over one synchronous serial link. The two encoders share a single active-low select line and a single serial clock, and each returns its bits on its own data input. A one-cycle enable pulse, `tick_i`, marks the 2 MHz base rate and paces every edge the block drives. As a result the select pulse width, the clock half-period and the delay from select to the first clock edge are each one tick (500 ns).

A frame begins when a one-shot request is latched while the link is idle, or on every tick in free-running mode. Each frame is 38 ticks long. The block samples both data lines on every falling clock edge and throws away the first sample. The next twelve samples form the position, sent most significant bit first. The five samples after that form the status word. The parity bit sent after the status is never sampled. When the frame ends, the block updates both positions, both status words and their angles in degrees together, and pulses a valid strobe.

Top module: `ssi_dual_reader`

## Requirements
- R1: `cs_n_o` and `sclk_o` change only on the clock cycle that follows a cycle in which `tick_i` was high.
- R2: Counting ticks from the frame start as 0 to 37, `cs_n_o` is high during tick 0 and low during ticks 1 to 37, so one frame lasts 38 ticks.
- R3: `sclk_o` is high during ticks 0 and 1, low during even ticks 2 to 36 and high during odd ticks 3 to 37, which gives 18 falling edges per frame.
- R4: On each falling edge, each data input is sampled after a two-flop synchronizer. The first sample is dropped. The next 12 samples, most significant bit first, form the position. The 5 samples after those, most significant bit first, form the status. The bit that would follow these is not captured.
- R5: While idle, `cs_n_o` and `sclk_o` are high. A synchronous reset returns the block to idle at any point in a frame and clears `valid_o`, `pos_o`, `stat_o` and `deg_o`.
- R6: A high `start_i` is accepted only while idle. It starts exactly one frame at the next tick, and a `start_i` seen during a frame has no effect. While `free_run_i` is high, the next frame starts on the same tick that ends the previous one, so frames run back to back with no gap.
- R7: `valid_o` is a one-cycle pulse two clock cycles after the tick that ends tick 37. In that same cycle, `pos_o`, `stat_o` and `deg_o` take the new values, and they hold those values until the next pulse.
- R8: For each encoder, `deg_o` is an unsigned 16-bit value with 9 integer and 7 fraction bits, equal to (position × 45 + 2) >> 2. This is the angle position × 360 / 4096 rounded to 1/128 degree.
- R9: Encoder e uses `data_i[e]`, `pos_o[12e+11:12e]`, `stat_o[5e+4:5e]` and `deg_o[16e+15:16e]`. Both encoders are read in the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle 2 MHz pacing pulse |
| start_i | input | 1 | One-shot frame request |
| free_run_i | input | 1 | Run frames back to back |
| data_i | input | 2 | Serial data, one line per encoder |
| cs_n_o | output | 1 | Shared active-low select |
| sclk_o | output | 1 | Shared serial clock |
| valid_o | output | 1 | One-cycle result strobe |
| pos_o | output | 24 | Packed 12-bit positions |
| stat_o | output | 10 | Packed 5-bit status words |
| deg_o | output | 32 | Packed 9.7 fixed-point angles |

## Verification
The bench sends the extreme codes 0 and 4095 and alternating bit patterns. These expose a position shifted by one bit, which happens when the leading sample is kept or the parity bit is taken in. The two encoders always carry different words, so swapped or shared data lines show up as wrong positions. A start pulse in the middle of a frame, a reset in the middle of a frame, and free-running frames with new words each time test the request and idle rules. A wrong rule here shows up as an extra or missing select pulse, a stretched gap between frames, or stale results left after reset. The rounding of the angle is checked at codes where the fraction falls halfway between steps.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
    localparam int POS_W       = 12;
    localparam int STAT_W      = 5;
    localparam int WORD_W      = POS_W + STAT_W;
    localparam int FRAME_TICKS = 38;
    localparam int IDX_W       = $clog2(FRAME_TICKS);
    localparam int DEG_W       = 16;
    localparam int DEG_FRAC    = 7;
    localparam int DEG_LIMIT   = 360 << DEG_FRAC;

    typedef enum logic { SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1 } seq_state_e;

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [STAT_W-1:0] stat;
    } enc_word_t;

    // clock level for a given frame tick: high on the two leading ticks, then odd ticks
    function automatic logic clk_level(input logic [IDX_W-1:0] idx);
        return (idx < IDX_W'(2)) ? 1'b1 : idx[0];
    endfunction

    // count * 360 / 4096 scaled by 128, rounded: (count * 45 + 2) >> 2
    function automatic logic [DEG_W-1:0] deg_of(input logic [POS_W-1:0] cnt);
        logic [DEG_W+1:0] prod;
        prod = ((DEG_W+2)'(cnt) * (DEG_W+2)'(45)) + (DEG_W+2)'(2);
        return prod[DEG_W+1:2];
    endfunction
endpackage

// File: rtl/ssi_sync.sv
module ssi_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/ssi_frame_seq.sv
module ssi_frame_seq
    import ssi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic start_i,
    input  logic free_run_i,
    output logic cs_n_o,
    output logic sclk_o,
    output logic sample_o,
    output logic first_o,
    output logic done_o
);
    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nx;
    logic             pend_q;
    logic             last_tick;
    logic             go;

    always_comb begin
        idx_nx    = idx_q + IDX_W'(1);
        last_tick = (state_q == SEQ_RUN) && (idx_q == IDX_W'(FRAME_TICKS - 1));
        go        = free_run_i || pend_q || (start_i && state_q == SEQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            idx_q    <= '0;
            pend_q   <= 1'b0;
            cs_n_o   <= 1'b1;
            sclk_o   <= 1'b1;
            sample_o <= 1'b0;
            first_o  <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            sample_o <= 1'b0;
            first_o  <= 1'b0;
            done_o   <= 1'b0;
            if (start_i && state_q == SEQ_IDLE) begin
                pend_q <= 1'b1;
            end
            if (tick_i) begin
                if (state_q == SEQ_RUN && !last_tick) begin
                    idx_q  <= idx_nx;
                    cs_n_o <= 1'b0;
                    sclk_o <= clk_level(idx_nx);
                    if (!clk_level(idx_nx)) begin
                        sample_o <= 1'b1;
                        first_o  <= (idx_nx == IDX_W'(2));
                    end
                end else begin
                    done_o <= last_tick;
                    idx_q  <= '0;
                    cs_n_o <= 1'b1;
                    sclk_o <= 1'b1;
                    if (go) begin
                        state_q <= SEQ_RUN;
                        pend_q  <= 1'b0;
                    end else begin
                        state_q <= SEQ_IDLE;
                    end
                end
            end
        end
    end

    assert_tick_paced_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(tick_i) |-> ($stable(cs_n_o) && $stable(sclk_o)));

    assert_cs_fall_clk_high_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> sclk_o);

    assert_clk_fall_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> !cs_n_o);

    assert_sample_on_low_R4: assert property (@(posedge clk) disable iff (rst)
        sample_o |-> (!sclk_o && !cs_n_o));

    assert_idle_lines_high_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE) |-> (cs_n_o && sclk_o));
endmodule

// File: rtl/ssi_capture.sv
module ssi_capture
    import ssi_pkg::*;
#(
    parameter bit DEG_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_i,
    input  logic             first_i,
    input  logic             done_i,
    input  logic             bit_i,
    output enc_word_t        word_o,
    output logic [DEG_W-1:0] deg_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] shift_q;
    enc_word_t         word_q;
    logic [CNT_W-1:0]  shift_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            word_q  <= '0;
        end else begin
            if (sample_i && !first_i) begin
                shift_q <= {shift_q[WORD_W-2:0], bit_i};
            end
            if (done_i) begin
                word_q <= enc_word_t'(shift_q);
            end
        end
    end

    generate
        if (DEG_EN) begin : g_deg
            logic [DEG_W-1:0] deg_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    deg_q <= '0;
                end else if (done_i) begin
                    deg_q <= deg_of(shift_q[WORD_W-1:STAT_W]);
                end
            end
            assign deg_o = deg_q;
        end else begin : g_no_deg
            assign deg_o = '0;
        end
    endgenerate

    assign word_o = word_q;

    // checker state: bits kept since the previous frame end
    always_ff @(posedge clk) begin
        if (rst || done_i) begin
            shift_cnt <= '0;
        end else if (sample_i && !first_i && shift_cnt != CNT_W'(WORD_W + 1)) begin
            shift_cnt <= shift_cnt + CNT_W'(1);
        end
    end

    assert_kept_bit_count_R4: assert property (@(posedge clk) disable iff (rst)
        done_i |-> (shift_cnt == CNT_W'(WORD_W)));
endmodule

// File: rtl/ssi_dual_reader.sv
module ssi_dual_reader
    import ssi_pkg::*;
#(
    parameter int N_ENC  = 2,
    parameter bit DEG_EN = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick_i,
    input  logic                      start_i,
    input  logic                      free_run_i,
    input  logic [N_ENC-1:0]          data_i,
    output logic                      cs_n_o,
    output logic                      sclk_o,
    output logic                      valid_o,
    output logic [N_ENC*POS_W-1:0]    pos_o,
    output logic [N_ENC*STAT_W-1:0]   stat_o,
    output logic [N_ENC*DEG_W-1:0]    deg_o
);
    logic             sample;
    logic             first;
    logic             done;
    logic [N_ENC-1:0] data_sync;
    logic             valid_q;

    ssi_sync #(.W(N_ENC)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (data_i),
        .q_o (data_sync)
    );

    ssi_frame_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .start_i    (start_i),
        .free_run_i (free_run_i),
        .cs_n_o     (cs_n_o),
        .sclk_o     (sclk_o),
        .sample_o   (sample),
        .first_o    (first),
        .done_o     (done)
    );

    generate
        for (genvar e = 0; e < N_ENC; e++) begin : g_enc
            enc_word_t        word;
            logic [DEG_W-1:0] deg;

            ssi_capture #(.DEG_EN(DEG_EN)) cap_i (
                .clk      (clk),
                .rst      (rst),
                .sample_i (sample),
                .first_i  (first),
                .done_i   (done),
                .bit_i    (data_sync[e]),
                .word_o   (word),
                .deg_o    (deg)
            );

            assign pos_o[e*POS_W +: POS_W]    = word.pos;
            assign stat_o[e*STAT_W +: STAT_W] = word.stat;
            assign deg_o[e*DEG_W +: DEG_W]    = deg;

            assert_deg_in_range_R8: assert property (@(posedge clk) disable iff (rst)
                valid_o |-> (deg_o[e*DEG_W +: DEG_W] < DEG_W'(DEG_LIMIT)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= done;
        end
    end

    assign valid_o = valid_q;

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_results_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !valid_o && !$past(rst) |-> ($stable(pos_o) && $stable(stat_o)));
endmodule

// File: tb/ssi_dual_reader_tb_top.sv
module ssi_dual_reader_tb_top;
    localparam int TICK_DIV = 6;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic        free_run = 1'b0;
    logic [1:0]  data;
    logic        cs_n;
    logic        sclk;
    logic        valid;
    logic [23:0] pos;
    logic [9:0]  stat;
    logic [31:0] deg;

    int checks = 0;
    int errors = 0;
    int valid_seen = 0;
    bit model_live = 1'b0;

    always #4 clk = ~clk;

    ssi_dual_reader dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .start_i    (start),
        .free_run_i (free_run),
        .data_i     (data),
        .cs_n_o     (cs_n),
        .sclk_o     (sclk),
        .valid_o    (valid),
        .pos_o      (pos),
        .stat_o     (stat),
        .deg_o      (deg)
    );

    // ---------------- encoder models ----------------
    logic [11:0] enc_pos [2];
    logic [4:0]  enc_stat[2];
    logic [11:0] lat_pos [2];
    logic [4:0]  lat_stat[2];
    int          kcnt = 0;

    function automatic logic enc_bit(input logic [11:0] p, input logic [4:0] s, input int k);
        logic [18:0] w;
        w = {1'b1, p, s, ^{p, s}};
        if (k > 18) return 1'b0;
        return w[18-k];
    endfunction

    always @(negedge cs_n) begin
        for (int e = 0; e < 2; e++) begin
            lat_pos[e]  = enc_pos[e];
            lat_stat[e] = enc_stat[e];
        end
    end

    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) kcnt = 0;
        else      kcnt = kcnt + 1;
    end

    always_comb begin
        for (int e = 0; e < 2; e++) begin
            data[e] = (cs_n !== 1'b0) ? 1'b1 : enc_bit(lat_pos[e], lat_stat[e], kcnt);
        end
    end

    // ---------------- behavioural reference ----------------
    bit          m_busy, m_pend, m_cs, m_ck, m_end, m_go;
    int          m_idx;
    bit [1:0]    m_v;
    int          m_pos [2];
    int          m_stat[2];

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_pend = 0; m_idx = 0; m_cs = 1; m_ck = 1; m_v = 2'b00;
            for (int e = 0; e < 2; e++) begin m_pos[e] = 0; m_stat[e] = 0; end
        end else begin
            m_end = 0;
            m_go  = free_run || m_pend || (start && !m_busy);
            if (start && !m_busy) m_pend = 1;
            if (tick) begin
                if (m_busy && m_idx < 37) begin
                    m_idx = m_idx + 1;
                    m_cs  = 0;
                    m_ck  = (m_idx < 2) ? 1'b1 : ((m_idx % 2) == 1);
                end else begin
                    m_end = m_busy && (m_idx == 37);
                    m_cs = 1; m_ck = 1; m_idx = 0;
                    if (m_go) begin m_busy = 1; m_pend = 0; end
                    else m_busy = 0;
                end
            end
            m_v = {m_v[0], m_end};
            if (m_v[1]) begin
                for (int e = 0; e < 2; e++) begin
                    m_pos[e]  = lat_pos[e];
                    m_stat[e] = lat_stat[e];
                end
            end
        end
        model_live = 1'b1;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (model_live) begin
            chk(cs_n === m_cs, "R1 R2 select line", int'(cs_n), int'(m_cs));
            chk(sclk === m_ck, "R1 R3 serial clock", int'(sclk), int'(m_ck));
            chk(valid === m_v[1], "R7 valid strobe", int'(valid), int'(m_v[1]));
            if (valid === 1'b1) valid_seen++;
            for (int e = 0; e < 2; e++) begin
                chk(pos[e*12 +: 12] === 12'(m_pos[e]), "R4 R9 position", int'(pos[e*12 +: 12]), m_pos[e]);
                chk(stat[e*5 +: 5] === 5'(m_stat[e]), "R4 R9 status", int'(stat[e*5 +: 5]), m_stat[e]);
                chk(deg[e*16 +: 16] === 16'((m_pos[e] * 45 + 2) >>> 2), "R8 degrees",
                    int'(deg[e*16 +: 16]), (m_pos[e] * 45 + 2) >>> 2);
            end
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic set_words(input int p0, input int s0, input int p1, input int s1);
        enc_pos[0] = 12'(p0); enc_stat[0] = 5'(s0);
        enc_pos[1] = 12'(p1); enc_stat[1] = 5'(s1);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic one_frame(input int p0, input int s0, input int p1, input int s1);
        set_words(p0, s0, p1, s1);
        pulse_start();
        repeat (TICK_DIV * 42) @(negedge clk);
    endtask

    initial begin
        set_words(0, 0, 0, 0);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5: reset state at the ports
        chk(cs_n === 1'b1 && sclk === 1'b1, "R5 idle lines after reset", int'({cs_n, sclk}), 3);
        chk(valid === 1'b0 && pos === '0, "R5 cleared results", int'(pos), 0);

        one_frame(12'h000, 5'h00, 12'hFFF, 5'h1F);
        one_frame(12'hA5C, 5'h15, 12'h3A1, 5'h0A);
        one_frame(12'h800, 5'h10, 12'h001, 5'h01);
        one_frame(12'h555, 5'h0E, 12'hAAA, 5'h11);
        one_frame(12'h003, 5'h1B, 12'h002, 5'h04);

        // R6: a start request during a frame is ignored
        valid_seen = 0;
        set_words(12'h7F0, 5'h03, 12'h0F7, 5'h1C);
        pulse_start();
        repeat (TICK_DIV * 10) @(negedge clk);
        pulse_start();
        repeat (TICK_DIV * 80) @(negedge clk);
        chk(valid_seen == 1, "R6 start during frame ignored", valid_seen, 1);

        // R6: free-running frames back to back with fresh words
        valid_seen = 0;
        free_run = 1'b1;
        for (int f = 0; f < 4; f++) begin
            do @(negedge clk); while (valid !== 1'b1);
            set_words(f * 1000 + 7, f * 5 + 1, 4095 - f * 999, 31 - f * 3);
        end
        free_run = 1'b0;
        repeat (TICK_DIV * 80) @(negedge clk);
        chk(valid_seen >= 5, "R6 free-running frames", valid_seen, 5);

        // R5: reset part way through a frame
        set_words(12'h9C4, 5'h12, 12'h4B1, 5'h08);
        pulse_start();
        repeat (TICK_DIV * 15) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b1, "R5 idle after mid-frame reset", int'({cs_n, sclk}), 3);
        chk(pos === '0 && stat === '0 && deg === '0, "R5 results cleared by reset", int'(pos), 0);
        repeat (TICK_DIV * 45) @(negedge clk);
        chk(valid_seen >= 5 && cs_n === 1'b1, "R6 no frame after reset without request", int'(cs_n), 1);

        one_frame(12'h9C4, 5'h12, 12'h4B1, 5'h08);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule